// File: doc/BRIEF.md
# Packetized Video Frame Clipper

This block crops a packetized pixel stream to a rectangular window. Every field opens with a single-beat dimension packet that gives the field's width and height. One line packet follows for each video line, one pixel per beat, and each line packet ends with an end-of-packet marker. The block rewrites the dimension packet so that it states the clipped size. It then forwards only the lines and pixels inside the window. Every pixel and line outside the window is consumed without producing an output beat. A single-beat commit packet can also arrive on the stream. It never reaches the output.

Software sets the window through a small register port: left offset, top offset, requested width and requested height. These writes go into shadow registers. A commit is armed either by writing the commit register or by a commit packet on the stream. The shadow values are then copied into the active set when the next dimension packet is accepted. As a result, one field is always clipped with a single consistent window. An optional debug group reports the dimensions of the latest incoming field and a running field count.

Top module: `vid_clipper`

## Requirements
- R1: After reset, `m_valid` is low, the field count reads 0 and the shadow window is full-pass (offsets 0, width and height all ones). Line beats that arrive before the first dimension packet are consumed and produce no output.
- R2: `s_kind` encodes 0 = line pixel, 1 = dimension packet, 2 = commit packet, 3 = discarded. A dimension beat carries the width in `data[DIMW-1:0]` and the height in `data[2*DIMW-1:DIMW]`. The block emits it as one beat with `m_info`, `m_sop` and `m_eop` all high, and with the clipped dimensions in those same fields.
- R3: The clipped width is the smaller of the requested width and the input width minus the left offset, clamped at 0. The clipped height follows the same rule with the top offset. A field that already fits inside the window passes through unchanged.
- R4: Only input lines with index from top to top+height-1 are forwarded. Each forwarded line holds the pixels from column left onward, with `m_sop` on its first beat and `m_eop` on its last.
- R5: Writes to the window registers (addresses 0 to 3) have no effect until a commit. A commit is a write to address 4 or a commit packet. It takes effect at the next accepted dimension packet. A commit write in the same cycle as an accepted dimension beat applies to that field.
- R6: Every output line has exactly the clipped width. A short input line is completed with zero pixels after its end-of-packet, and the extra beats of a long line are dropped.
- R7: Reads return data one cycle after `reg_rd`. Addresses 0 to 3 read the shadow window. Addresses 5 and 6 read the latest incoming width and height, and address 7 reads the field count (0 when debug is disabled).
- R8: While `m_valid` is high and `m_ready` is low, every output holds its value, and no beat is lost under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | DW | Pixel or dimension payload |
| s_kind | input | 2 | Beat kind: 0 line, 1 dimension, 2 commit, 3 discarded |
| s_eop | input | 1 | Last beat of a line packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DW | Output pixel or clipped dimensions |
| m_info | output | 1 | Output beat is a dimension packet |
| m_sop | output | 1 | First beat of an output packet |
| m_eop | output | 1 | Last beat of an output packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DIMW | Register write data |
| reg_rdata | output | REGW | Registered read data |

## Verification
A commit and a field boundary can land in the same cycle: a write to the commit register while the dimension beat is being accepted. The bench provokes this by driving both strobes in one cycle, with the output register empty and `m_ready` high. It first confirms that `s_ready` was high in that cycle. It then expects the rewritten dimension packet and all following lines to use the new shadow window rather than the old active one. A second overlap appears when a short line's padding stalls the input while downstream applies random backpressure. There the bench compares every beat against its own model of the window.

// File: rtl/vclip_pkg.sv
package vclip_pkg;
  typedef enum logic [1:0] {
    PK_LINE   = 2'd0,
    PK_INFO   = 2'd1,
    PK_COMMIT = 2'd2,
    PK_RSVD   = 2'd3
  } pkt_kind_e;

  localparam logic [2:0] RA_LEFT   = 3'd0;
  localparam logic [2:0] RA_TOP    = 3'd1;
  localparam logic [2:0] RA_WIDTH  = 3'd2;
  localparam logic [2:0] RA_HEIGHT = 3'd3;
  localparam logic [2:0] RA_COMMIT = 3'd4;
  localparam logic [2:0] RA_IN_W   = 3'd5;
  localparam logic [2:0] RA_IN_H   = 3'd6;
  localparam logic [2:0] RA_FCOUNT = 3'd7;
endpackage

// File: rtl/vclip_regs.sv
module vclip_regs
  import vclip_pkg::*;
#(
  parameter int DIMW     = 12,
  parameter int REGW     = 16,
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [DIMW-1:0] reg_wdata,
  output logic [REGW-1:0] reg_rdata,
  input  logic            commit_pkt_i,
  input  logic            field_start_i,
  input  logic [DIMW-1:0] in_w_i,
  input  logic [DIMW-1:0] in_h_i,
  output logic [DIMW-1:0] sel_left,
  output logic [DIMW-1:0] sel_top,
  output logic [DIMW-1:0] sel_w,
  output logic [DIMW-1:0] sel_h
);
  logic [DIMW-1:0] sh_l, sh_t, sh_w, sh_h;
  logic [DIMW-1:0] ac_l, ac_t, ac_w, ac_h;
  logic            pending;
  logic            commit_wr;
  logic            arm;
  logic [DIMW-1:0] dbg_w, dbg_h;
  logic [REGW-1:0] fcnt;

  assign commit_wr = reg_wr && (reg_addr == RA_COMMIT);
  assign arm       = pending || commit_wr || commit_pkt_i;

  // The window the next dimension packet will use
  assign sel_left = arm ? sh_l : ac_l;
  assign sel_top  = arm ? sh_t : ac_t;
  assign sel_w    = arm ? sh_w : ac_w;
  assign sel_h    = arm ? sh_h : ac_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_l    <= '0;
      sh_t    <= '0;
      sh_w    <= '1;
      sh_h    <= '1;
      ac_l    <= '0;
      ac_t    <= '0;
      ac_w    <= '1;
      ac_h    <= '1;
      pending <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_LEFT:   sh_l <= reg_wdata;
          RA_TOP:    sh_t <= reg_wdata;
          RA_WIDTH:  sh_w <= reg_wdata;
          RA_HEIGHT: sh_h <= reg_wdata;
          default: ;
        endcase
      end
      if (field_start_i) begin
        if (arm) begin
          ac_l <= sh_l;
          ac_t <= sh_t;
          ac_w <= sh_w;
          ac_h <= sh_h;
        end
        pending <= 1'b0;
      end else if (commit_wr || commit_pkt_i) begin
        pending <= 1'b1;
      end
    end
  end

  generate
    if (DEBUG_EN) begin : g_dbg
      always_ff @(posedge clk) begin
        if (rst) begin
          dbg_w <= '0;
          dbg_h <= '0;
          fcnt  <= '0;
        end else if (field_start_i) begin
          dbg_w <= in_w_i;
          dbg_h <= in_h_i;
          fcnt  <= fcnt + 1'b1;
        end
      end
    end else begin : g_nodbg
      assign dbg_w = '0;
      assign dbg_h = '0;
      assign fcnt  = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_LEFT:   reg_rdata <= REGW'(sh_l);
        RA_TOP:    reg_rdata <= REGW'(sh_t);
        RA_WIDTH:  reg_rdata <= REGW'(sh_w);
        RA_HEIGHT: reg_rdata <= REGW'(sh_h);
        RA_IN_W:   reg_rdata <= REGW'(dbg_w);
        RA_IN_H:   reg_rdata <= REGW'(dbg_h);
        RA_FCOUNT: reg_rdata <= fcnt;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_COMMIT_AT_FIELD: assert property (@(posedge clk) disable iff (rst)
    field_start_i && pending |=> !pending && (ac_w == $past(sh_w)) && (ac_l == $past(sh_l))) // R5
    else $error("commit not applied at field start");
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !field_start_i |=> $stable(ac_w) && $stable(ac_h) && $stable(ac_l) && $stable(ac_t)) // R5
    else $error("active window changed outside a field start");
endmodule

// File: rtl/vclip_stream.sv
module vclip_stream
  import vclip_pkg::*;
#(
  parameter int DW   = 24,
  parameter int DIMW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [DW-1:0]   s_data,
  input  logic [1:0]      s_kind,
  input  logic            s_eop,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [DW-1:0]   m_data,
  output logic            m_info,
  output logic            m_sop,
  output logic            m_eop,
  input  logic [DIMW-1:0] sel_left,
  input  logic [DIMW-1:0] sel_top,
  input  logic [DIMW-1:0] sel_w,
  input  logic [DIMW-1:0] sel_h,
  output logic            field_start_o,
  output logic            commit_pkt_o,
  output logic [DIMW-1:0] in_w_o,
  output logic [DIMW-1:0] in_h_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_LINE, ST_PAD} st_e;

  st_e             state;
  logic [DIMW-1:0] row, icol, ocol;
  logic [DIMW-1:0] act_l, act_t, ow, oh;
  logic [DW-1:0]   o_data;
  logic            o_valid, o_info, o_sop, o_eop;

  logic            can_load, take;
  pkt_kind_e       kind;
  logic [DIMW-1:0] new_ow, new_oh, ocol_next;
  logic            row_hit, col_hit, emit, short_line;

  function automatic logic [DIMW-1:0] clip_len(input logic [DIMW-1:0] full,
                                               input logic [DIMW-1:0] off,
                                               input logic [DIMW-1:0] req);
    logic [DIMW-1:0] room;
    room = (full > off) ? (full - off) : '0;
    return (req < room) ? req : room;
  endfunction

  assign can_load  = !o_valid || m_ready;
  assign s_ready   = can_load && (state != ST_PAD);
  assign take      = s_valid && s_ready;
  assign kind      = pkt_kind_e'(s_kind);
  assign in_w_o    = s_data[DIMW-1:0];
  assign in_h_o    = s_data[2*DIMW-1:DIMW];
  assign new_ow    = clip_len(in_w_o, sel_left, sel_w);
  assign new_oh    = clip_len(in_h_o, sel_top, sel_h);

  assign row_hit   = ({1'b0, row} >= {1'b0, act_t}) &&
                     ({1'b0, row} < ({1'b0, act_t} + {1'b0, oh}));
  assign col_hit   = (icol >= act_l) && (ocol < ow);
  assign emit      = row_hit && col_hit;
  assign ocol_next = ocol + {{(DIMW-1){1'b0}}, emit};
  assign short_line = row_hit && s_eop && (ocol_next < ow);

  assign field_start_o = take && (kind == PK_INFO);
  assign commit_pkt_o  = take && (kind == PK_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      row     <= '0;
      icol    <= '0;
      ocol    <= '0;
      act_l   <= '0;
      act_t   <= '0;
      ow      <= '0;
      oh      <= '0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_info  <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
    end else begin
      if (can_load) o_valid <= 1'b0;
      if (take && kind == PK_INFO) begin
        o_valid <= 1'b1;
        o_info  <= 1'b1;
        o_sop   <= 1'b1;
        o_eop   <= 1'b1;
        o_data  <= DW'({new_oh, new_ow});
        act_l   <= sel_left;
        act_t   <= sel_top;
        ow      <= new_ow;
        oh      <= new_oh;
        row     <= '0;
        icol    <= '0;
        ocol    <= '0;
        state   <= ST_LINE;
      end else if (take && kind == PK_LINE && state == ST_LINE) begin
        if (emit) begin
          o_valid <= 1'b1;
          o_info  <= 1'b0;
          o_data  <= s_data;
          o_sop   <= (ocol == '0);
          o_eop   <= (ocol_next == ow);
        end
        if (s_eop) begin
          icol <= '0;
          if (short_line) begin
            ocol  <= ocol_next;
            state <= ST_PAD;
          end else begin
            ocol <= '0;
            if (row != '1) row <= row + 1'b1;
          end
        end else begin
          if (icol != '1) icol <= icol + 1'b1;
          ocol <= ocol_next;
        end
      end else if (state == ST_PAD && can_load) begin
        o_valid <= 1'b1;
        o_info  <= 1'b0;
        o_data  <= '0;
        o_sop   <= (ocol == '0);
        o_eop   <= (ocol + 1'b1 == ow);
        if (ocol + 1'b1 == ow) begin
          ocol  <= '0;
          state <= ST_LINE;
          if (row != '1) row <= row + 1'b1;
        end else begin
          ocol <= ocol + 1'b1;
        end
      end
    end
  end

  assign m_valid = o_valid;
  assign m_data  = o_data;
  assign m_info  = o_info;
  assign m_sop   = o_sop;
  assign m_eop   = o_eop;

  // Checker counters over accepted output beats
  logic [DIMW:0] lcnt, lines_out;
  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt      <= '0;
      lines_out <= '0;
    end else if (o_valid && m_ready) begin
      if (o_info) begin
        lcnt      <= '0;
        lines_out <= '0;
      end else if (o_eop) begin
        lcnt      <= '0;
        lines_out <= lines_out + 1'b1;
      end else begin
        lcnt <= lcnt + 1'b1;
      end
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    o_valid && !m_ready |=> o_valid && $stable(o_data) && $stable(o_sop) && $stable(o_eop) && $stable(o_info)) // R8
    else $error("output changed while stalled");
  AST_LINE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    o_valid && m_ready && !o_info && o_eop |-> (lcnt + 1'b1) == {1'b0, ow}) // R6
    else $error("output line length differs from clipped width");
  AST_LINE_COUNT: assert property (@(posedge clk) disable iff (rst)
    o_valid && m_ready && !o_info && o_eop |-> lines_out < {1'b0, oh}) // R4
    else $error("too many output lines");
  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_info |-> (o_sop == (lcnt == '0))) // R4
    else $error("start marker misplaced");
endmodule

// File: rtl/vid_clipper.sv
module vid_clipper #(
  parameter int DW       = 24,
  parameter int DIMW     = 12,
  parameter int REGW     = 16,
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [DW-1:0]   s_data,
  input  logic [1:0]      s_kind,
  input  logic            s_eop,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [DW-1:0]   m_data,
  output logic            m_info,
  output logic            m_sop,
  output logic            m_eop,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [DIMW-1:0] reg_wdata,
  output logic [REGW-1:0] reg_rdata
);
  logic [DIMW-1:0] sel_left, sel_top, sel_w, sel_h;
  logic [DIMW-1:0] in_w, in_h;
  logic            field_start, commit_pkt;

  vclip_regs #(.DIMW(DIMW), .REGW(REGW), .DEBUG_EN(DEBUG_EN)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .commit_pkt_i(commit_pkt), .field_start_i(field_start),
    .in_w_i(in_w), .in_h_i(in_h),
    .sel_left(sel_left), .sel_top(sel_top), .sel_w(sel_w), .sel_h(sel_h)
  );

  vclip_stream #(.DW(DW), .DIMW(DIMW)) u_stream (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_kind(s_kind), .s_eop(s_eop),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_info(m_info), .m_sop(m_sop), .m_eop(m_eop),
    .sel_left(sel_left), .sel_top(sel_top), .sel_w(sel_w), .sel_h(sel_h),
    .field_start_o(field_start), .commit_pkt_o(commit_pkt),
    .in_w_o(in_w), .in_h_o(in_h)
  );
endmodule

// File: tb/vid_clipper_bench.sv
module vid_clipper_bench;
  localparam int CLK_NS = 10;
  localparam int DW = 24;
  localparam int DIMW = 12;
  localparam int REGW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            s_valid = 1'b0;
  logic            s_ready;
  logic [DW-1:0]   s_data = '0;
  logic [1:0]      s_kind = 2'd0;
  logic            s_eop = 1'b0;
  logic            m_valid;
  logic            m_ready = 1'b1;
  logic [DW-1:0]   m_data;
  logic            m_info, m_sop, m_eop;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [2:0]      reg_addr = 3'd0;
  logic [DIMW-1:0] reg_wdata = '0;
  logic [REGW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int nfields = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef logic [DW+2:0] beat_t;
  beat_t got[$];
  beat_t exp_q[$];
  beat_t held;
  bit    hold_seen = 1'b0;

  vid_clipper u_vid_clipper (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_kind(s_kind), .s_eop(s_eop), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_info(m_info), .m_sop(m_sop), .m_eop(m_eop),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = lfsr[0];
    end else begin
      m_ready = 1'b1;
    end
  end

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_seen) begin
        checks++;
        if (!m_valid || {m_info, m_sop, m_eop, m_data} !== held) begin
          errors++;
          $display("FAIL R8 stalled beat changed actual %h expected %h", {m_info, m_sop, m_eop, m_data}, held);
        end
      end
      hold_seen = m_valid && !m_ready;
      held = {m_info, m_sop, m_eop, m_data};
      if (m_valid && m_ready) got.push_back({m_info, m_sop, m_eop, m_data});
    end
  end

  function automatic int clipv(int full, int off, int req);
    int room;
    room = (full > off) ? full - off : 0;
    return (req < room) ? req : room;
  endfunction

  function automatic logic [DW-1:0] pix(int r, int c);
    return DW'(24'h800000 | (r << 8) | c);
  endfunction

  task automatic exp_field(int iw, int ih, int len, int l, int t, int w, int h);
    int ow, oh;
    ow = clipv(iw, l, w);
    oh = clipv(ih, t, h);
    exp_q.push_back({1'b1, 1'b1, 1'b1, DW'((oh << DIMW) | ow)});
    for (int r = 0; r < ih; r++) begin
      if (r >= t && r < t + oh) begin
        for (int k = 0; k < ow; k++) begin
          int c;
          c = l + k;
          exp_q.push_back({1'b0, k == 0, k == ow - 1, (c < len) ? pix(r, c) : {DW{1'b0}}});
        end
      end
    end
  endtask

  task automatic send_beat(logic [1:0] k, logic [DW-1:0] d, logic e);
    bit acc;
    s_valid = 1'b1; s_kind = k; s_data = d; s_eop = e;
    do begin
      @(negedge clk); acc = s_ready;
      @(posedge clk);
    end while (!acc);
    #1;
    s_valid = 1'b0; s_eop = 1'b0;
  endtask

  task automatic send_lines(int ih, int len);
    for (int r = 0; r < ih; r++)
      for (int c = 0; c < len; c++)
        send_beat(2'd0, pix(r, c), c == len - 1);
  endtask

  task automatic send_field(int iw, int ih, int len);
    send_beat(2'd1, DW'((ih << DIMW) | iw), 1'b1);
    nfields++;
    send_lines(ih, len);
  endtask

  task automatic reg_write(logic [2:0] a, int v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DIMW'(v);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output int v);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic set_window(int l, int t, int w, int h);
    reg_write(3'd0, l); reg_write(3'd1, t); reg_write(3'd2, w); reg_write(3'd3, h);
  endtask

  task automatic check_val(string req, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic check_stream(string req);
    repeat (60) @(negedge clk);
    checks++;
    if (got.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s beat count actual %0d expected %0d", req, got.size(), exp_q.size());
    end
    for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
      checks++;
      if (got[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s beat %0d actual %h expected %h", req, i, got[i], exp_q[i]);
      end
    end
    got.delete(); exp_q.delete();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    int v;
    check_val("R1 m_valid after reset", int'(m_valid), 0);
    reg_read(3'd7, v); check_val("R1 field count", v, 0);
    reg_read(3'd2, v); check_val("R1 default width", v, 4095);
    reg_read(3'd0, v); check_val("R1 default left", v, 0);
    send_beat(2'd0, pix(0, 0), 1'b0);
    send_beat(2'd0, pix(0, 1), 1'b1);
    check_stream("R1 lines before dimension packet");
  endtask

  task automatic t_pass();
    exp_field(8, 6, 8, 0, 0, 4095, 4095);
    send_field(8, 6, 8);
    check_stream("R3 full-pass field");
  endtask

  task automatic t_clip();
    set_window(2, 1, 4, 3);
    reg_write(3'd4, 0);
    exp_field(8, 6, 8, 2, 1, 4, 3);
    send_field(8, 6, 8);
    check_stream("R2 R4 clipped field");
  endtask

  task automatic t_staged();
    reg_write(3'd2, 3);
    exp_field(8, 6, 8, 2, 1, 4, 3);
    send_field(8, 6, 8);
    check_stream("R5 write without commit");
    send_beat(2'd2, '0, 1'b1);
    exp_field(8, 6, 8, 2, 1, 3, 3);
    send_field(8, 6, 8);
    check_stream("R5 commit packet");
  endtask

  task automatic t_clamp();
    set_window(6, 5, 5, 4);
    reg_write(3'd4, 0);
    exp_field(8, 6, 8, 6, 5, 5, 4);
    send_field(8, 6, 8);
    check_stream("R3 clamp to remaining size");
    reg_write(3'd0, 9);
    reg_write(3'd4, 0);
    exp_field(8, 6, 8, 9, 5, 5, 4);
    send_field(8, 6, 8);
    check_stream("R3 offset beyond width");
  endtask

  task automatic t_short_long();
    set_window(2, 1, 4, 3);
    reg_write(3'd4, 0);
    exp_field(8, 6, 5, 2, 1, 4, 3);
    send_field(8, 6, 5);
    check_stream("R6 short lines padded");
    set_window(0, 0, 4095, 2);
    reg_write(3'd4, 0);
    exp_field(8, 4, 12, 0, 0, 4095, 2);
    send_field(8, 4, 12);
    check_stream("R6 long lines truncated");
  endtask

  task automatic t_collide();
    bit acc;
    set_window(1, 0, 5, 2);
    repeat (4) @(posedge clk); #1;
    s_valid = 1'b1; s_kind = 2'd1; s_data = DW'((6 << DIMW) | 8); s_eop = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = '0;
    @(negedge clk); acc = s_ready;
    @(posedge clk); #1;
    s_valid = 1'b0; reg_wr = 1'b0; s_eop = 1'b0;
    nfields++;
    check_val("R5 dimension beat accepted with commit write", int'(acc), 1);
    send_lines(6, 8);
    exp_field(8, 6, 8, 1, 0, 5, 2);
    check_stream("R5 same-cycle commit and field start");
  endtask

  task automatic t_debug();
    int v;
    reg_read(3'd5, v); check_val("R7 incoming width", v, 8);
    reg_read(3'd6, v); check_val("R7 incoming height", v, 6);
    reg_read(3'd7, v); check_val("R7 field count", v, nfields);
    reg_read(3'd0, v); check_val("R7 shadow left", v, 1);
  endtask

  task automatic t_backpressure();
    set_window(2, 1, 4, 3);
    reg_write(3'd4, 0);
    bp_en = 1'b1;
    exp_field(8, 6, 5, 2, 1, 4, 3);
    send_field(8, 6, 5);
    exp_field(8, 6, 8, 2, 1, 4, 3);
    send_field(8, 6, 8);
    repeat (40) @(posedge clk);
    bp_en = 1'b0;
    check_stream("R8 backpressure");
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_pass();
    t_clip();
    t_staged();
    t_clamp();
    t_short_long();
    t_collide();
    t_debug();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule